// File: doc/BRIEF.md
# Flash program-erase control sequencer

This block is the control-register state machine that runs high-voltage program and erase operations on an embedded flash array. Software writes a five-bit control word through a single-cycle write port and reads it back. The bits are enable-high-voltage, erase select, program select, erase-suspend and program-suspend. A separate interlock strobe arms the block before an operation may start. An array-integrity input, when high, blocks every start.

The single enable bit does several jobs, and what it does depends on the phase. Setting it starts an operation. Clearing it after completion terminates the operation. Clearing it while the operation is still busy aborts it. While an operation is suspended, the bit must be set before the suspend bit may be cleared to resume. An erase that is suspended can host one nested program operation. The high-voltage work is modelled by a down-counter of fixed latency for each phase. Writes are filtered by a fixed priority and by lock windows tied to the DONE edges.

Top module: `flash_pe_seq`

## Requirements
- R1: Synchronous active-high reset clears all control bits and the pass flag and sets DONE to 1. The control word encodes enable in bit 0, erase in bit 1, program in bit 2, erase-suspend in bit 3 and program-suspend in bit 4.
- R2: A legal start makes DONE low on the cycle after the write edge and keeps it low for OP_LAT cycles. DONE then rises and the pass flag becomes 1.
- R3: Setting the enable bit is dropped unless an interlock strobe has been taken since the last start. Each start consumes the interlock.
- R4: A start is dropped when the integrity input is high, or when neither erase nor program is selected.
- R5: Clearing the enable bit while DONE=1 after completion terminates the operation. DONE stays 1.
- R6: Clearing the enable bit while the operation is busy aborts it. The pass flag clears, and DONE stays low for ABT_LAT cycles while enable writes are ignored. A later start needs a fresh interlock.
- R7: Setting a suspend bit on a running, non-nested operation makes DONE rise after SUS_LAT cycles. Erase-suspend requires erase, and program-suspend requires a plain program. Enable writes are ignored until DONE rises.
- R8: Clearing the enable bit while suspended does not abort anything. DONE stays 1.
- R9: In erase-suspend with enable clear, the program bit may be set. An interlock plus an enable set then runs a nested program. Terminating it returns to erase-suspend with DONE=1.
- R10: Clearing a suspend bit resumes only when enable is 1 (and for erase, program is 0). DONE stays 1 for SUS_LAT cycles, then falls, with enable writes ignored in that window. The operation then runs OP_LAT cycles to completion.
- R11: The erase and program bits ignore writes while enable is 1 or an operation is active outside erase-suspend.
- R12: In one write, mode bits are applied before enable, and a suspend request wins over an enable change, which is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word write data |
| ilk_we | input | 1 | Interlock write strobe |
| aie | input | 1 | Array integrity enable; blocks starts when high |
| ctl_rdata | output | 5 | Control word readback |
| done | output | 1 | High when no high-voltage phase is busy |
| pass | output | 1 | Last operation completed without abort |

## Verification
A phase register that is wrong shows at DONE on the very next cycle. A lost abort or suspend also shows as a DONE edge arriving at the wrong latency count. A write gate that is wrong shows in the readback word one cycle after the offending write, so every directed step reads the word back right after its write. Checks are also placed on the exact cycle before and after each expected DONE edge, so a timer that is off by one cycle is caught. An interlock flag that is left armed shows later, as a start that should have been dropped.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  localparam int CTL_W  = 5;
  localparam int B_EHV  = 0;
  localparam int B_ERS  = 1;
  localparam int B_PGM  = 2;
  localparam int B_ESUS = 3;
  localparam int B_PSUS = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RUN, PH_FINISH, PH_SUSPING, PH_SUSP, PH_RESUMING, PH_ABORT
  } phase_e;
endpackage

// File: rtl/flash_pe_timer.sv
module flash_pe_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          fire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign fire = (cnt == CW'(1));
endmodule

// File: rtl/flash_pe_wrgate.sv
module flash_pe_wrgate
  import flash_pe_pkg::*;
(
  input  phase_e           ph,
  input  logic [CTL_W-1:0] ctl_q,
  input  logic             nested_q,
  input  logic             ilk_q,
  input  logic             aie,
  input  logic             we,
  input  logic [CTL_W-1:0] wd,
  output logic [CTL_W-1:0] ctl_n,
  output logic             launch,
  output logic             nest_go,
  output logic             abort,
  output logic             term,
  output logic             sus_go,
  output logic             res_go
);
  logic ehv_q, ers_q, pgm_q, esus_q, psus_q;
  logic ers_n, pgm_n, esus_n, psus_n, ehv_n;
  logic ehv_lock, start_ok;

  assign ehv_q  = ctl_q[B_EHV];
  assign ers_q  = ctl_q[B_ERS];
  assign pgm_q  = ctl_q[B_PGM];
  assign esus_q = ctl_q[B_ESUS];
  assign psus_q = ctl_q[B_PSUS];

  // mode bits first
  always_comb begin
    ers_n = ers_q;
    pgm_n = pgm_q;
    if (we && !ehv_q && ph == PH_IDLE) begin
      ers_n = wd[B_ERS];
      pgm_n = wd[B_PGM];
    end else if (we && !ehv_q && ph == PH_SUSP && esus_q && !nested_q) begin
      pgm_n = wd[B_PGM];
    end
  end

  // suspend bits second
  always_comb begin
    esus_n = esus_q;
    psus_n = psus_q;
    sus_go = 1'b0;
    res_go = 1'b0;
    if (we && ph == PH_RUN && ehv_q && !nested_q && !esus_q && !psus_q) begin
      if (wd[B_ESUS] && ers_q) begin
        esus_n = 1'b1;
        sus_go = 1'b1;
      end else if (wd[B_PSUS] && pgm_q && !ers_q) begin
        psus_n = 1'b1;
        sus_go = 1'b1;
      end
    end else if (we && ph == PH_SUSP && ehv_q && !nested_q) begin
      if (esus_q && !wd[B_ESUS] && !pgm_q) begin
        esus_n = 1'b0;
        res_go = 1'b1;
      end else if (psus_q && !wd[B_PSUS]) begin
        psus_n = 1'b0;
        res_go = 1'b1;
      end
    end
  end

  // enable bit last
  assign ehv_lock = sus_go || res_go ||
                    (ph inside {PH_SUSPING, PH_RESUMING, PH_ABORT});
  assign start_ok = ilk_q && !aie;

  always_comb begin
    ehv_n   = ehv_q;
    launch  = 1'b0;
    nest_go = 1'b0;
    abort   = 1'b0;
    term    = 1'b0;
    if (we && !ehv_lock && wd[B_EHV] != ehv_q) begin
      if (wd[B_EHV]) begin
        if (ph == PH_IDLE) begin
          if (start_ok && !esus_n && !psus_n && (ers_n || pgm_n)) begin
            ehv_n  = 1'b1;
            launch = 1'b1;
          end
        end else if (ph == PH_SUSP) begin
          if (esus_q && ers_n && pgm_n && !psus_q && !nested_q) begin
            if (start_ok) begin
              ehv_n   = 1'b1;
              nest_go = 1'b1;
            end
          end else begin
            ehv_n = 1'b1;
          end
        end
      end else begin
        if (ph == PH_RUN) begin
          ehv_n = 1'b0;
          abort = 1'b1;
        end else if (ph == PH_FINISH) begin
          ehv_n = 1'b0;
          term  = 1'b1;
        end else if (ph == PH_SUSP) begin
          ehv_n = 1'b0;
        end
      end
    end
  end

  always_comb begin
    ctl_n         = '0;
    ctl_n[B_EHV]  = ehv_n;
    ctl_n[B_ERS]  = ers_n;
    ctl_n[B_PGM]  = pgm_n;
    ctl_n[B_ESUS] = esus_n;
    ctl_n[B_PSUS] = psus_n;
  end
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import flash_pe_pkg::*;
#(
  parameter int OP_LAT  = 20,
  parameter int SUS_LAT = 4,
  parameter int ABT_LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             ilk_we,
  input  logic             aie,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             done,
  output logic             pass
);
  localparam int CW = $clog2(OP_LAT + SUS_LAT + ABT_LAT + 1);

  phase_e           ph, ph_n;
  logic [CTL_W-1:0] ctl_q, ctl_n;
  logic             nested_q, nested_n, ilk_q, ilk_n, pass_n;
  logic             launch, nest_go, abort, term, sus_go, res_go;
  logic             fire, t_load;
  logic [CW-1:0]    t_len;

  flash_pe_wrgate u_gate (
    .ph(ph), .ctl_q(ctl_q), .nested_q(nested_q), .ilk_q(ilk_q), .aie(aie),
    .we(ctl_we), .wd(ctl_wdata), .ctl_n(ctl_n), .launch(launch),
    .nest_go(nest_go), .abort(abort), .term(term), .sus_go(sus_go),
    .res_go(res_go)
  );

  flash_pe_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .len(t_len), .fire(fire)
  );

  always_comb begin
    ph_n = ph;
    unique case (ph)
      PH_IDLE:     if (launch) ph_n = PH_RUN;
      PH_RUN: begin
        if (sus_go)     ph_n = PH_SUSPING;
        else if (abort) ph_n = PH_ABORT;
        else if (fire)  ph_n = PH_FINISH;
      end
      PH_FINISH:   if (term) ph_n = nested_q ? PH_SUSP : PH_IDLE;
      PH_SUSPING:  if (fire) ph_n = PH_SUSP;
      PH_SUSP: begin
        if (nest_go)     ph_n = PH_RUN;
        else if (res_go) ph_n = PH_RESUMING;
      end
      PH_RESUMING: if (fire) ph_n = PH_RUN;
      PH_ABORT:    if (fire) ph_n = nested_q ? PH_SUSP : PH_IDLE;
      default:     ph_n = PH_IDLE;
    endcase
  end

  always_comb begin
    t_load = (ph_n != ph) &&
             (ph_n inside {PH_RUN, PH_SUSPING, PH_RESUMING, PH_ABORT});
    unique case (ph_n)
      PH_RUN:   t_len = CW'(OP_LAT);
      PH_ABORT: t_len = CW'(ABT_LAT);
      default:  t_len = CW'(SUS_LAT);
    endcase
  end

  always_comb begin
    nested_n = nested_q;
    if (nest_go) nested_n = 1'b1;
    else if ((ph == PH_FINISH && term) || (ph == PH_ABORT && fire))
      nested_n = 1'b0;

    ilk_n = ilk_q;
    if (launch || nest_go) ilk_n = 1'b0;
    else if (ilk_we && !ctl_q[B_EHV] && (ph == PH_IDLE || ph == PH_SUSP))
      ilk_n = 1'b1;

    pass_n = pass;
    if (ph == PH_RUN && ph_n == PH_FINISH) pass_n = 1'b1;
    else if (abort)                         pass_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      ctl_q    <= '0;
      nested_q <= 1'b0;
      ilk_q    <= 1'b0;
      done     <= 1'b1;
      pass     <= 1'b0;
    end else begin
      ph       <= ph_n;
      ctl_q    <= ctl_n;
      nested_q <= nested_n;
      ilk_q    <= ilk_n;
      done     <= !(ph_n inside {PH_RUN, PH_SUSPING, PH_ABORT});
      pass     <= pass_n;
    end
  end

  assign ctl_rdata = ctl_q;
endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk
  import flash_pe_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             aie,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic             done,
  input logic             pass
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (ctl_rdata == '0 && done && !pass)); // R1

  AST_START_NEEDS_NO_AIE: assert property (@(posedge clk) disable iff (rst)
    ($rose(ctl_rdata[B_EHV]) && $fell(done)) |-> !$past(aie)); // R4

  AST_ABORT_CLEARS_PASS: assert property (@(posedge clk) disable iff (rst)
    ($fell(ctl_rdata[B_EHV]) && !$past(done)) |-> !pass); // R6

  AST_EHV_SET_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_rdata[B_EHV]) |-> $past(done)); // R6

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata[B_EHV] && $past(ctl_rdata[B_EHV])) |->
      ($stable(ctl_rdata[B_ERS]) && $stable(ctl_rdata[B_PGM]))); // R11

  AST_BUSY_NEEDS_EHV: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> ctl_rdata[B_EHV]); // R2

  AST_ESUS_ON_ERASE: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_rdata[B_ESUS]) |-> (ctl_rdata[B_ERS] && ctl_rdata[B_EHV])); // R7
endmodule

bind flash_pe_seq flash_pe_seq_chk u_chk (
  .clk(clk), .rst(rst), .aie(aie), .ctl_rdata(ctl_rdata),
  .done(done), .pass(pass)
);

// File: tb/flash_pe_seq_bench.sv
module flash_pe_seq_bench;
  localparam int OPL = 20;
  localparam int SPL = 4;
  localparam int ABL = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_we = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic       ilk_we = 1'b0;
  logic       aie = 1'b0;
  logic [4:0] ctl_rdata;
  logic       done, pass;
  int         n_chk = 0;
  int         n_bad = 0;

  flash_pe_seq #(.OP_LAT(OPL), .SUS_LAT(SPL), .ABT_LAT(ABL)) u_flash_pe_seq (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ilk_we(ilk_we), .aie(aie), .ctl_rdata(ctl_rdata), .done(done), .pass(pass)
  );

  always #10 clk = ~clk;

  task automatic ck(input string r, input logic [4:0] c, input logic d, input logic p);
    n_chk++;
    if ({ctl_rdata, done, pass} !== {c, d, p}) begin
      n_bad++;
      $display("FAIL %s: ctl=%b done=%b pass=%b expected ctl=%b done=%b pass=%b",
               r, ctl_rdata, done, pass, c, d, p);
    end
  endtask

  task automatic wr(input logic [4:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic ilk();
    ilk_we = 1'b1;
    @(negedge clk);
    ilk_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    ck("R1 reset", 5'b00000, 1'b1, 1'b0);
  endtask

  task automatic t_erase();
    wr(5'b00010);     ck("R11 ers write idle", 5'b00010, 1, 0);
    wr(5'b00011);     ck("R3 no interlock", 5'b00010, 1, 0);
    ilk();
    wr(5'b00011);     ck("R2 start", 5'b00011, 0, 0);
    idle(OPL - 1);    ck("R2 still busy", 5'b00011, 0, 0);
    idle(1);          ck("R2 complete", 5'b00011, 1, 1);
    wr(5'b00010);     ck("R5 terminate", 5'b00010, 1, 1);
    wr(5'b00000);
  endtask

  task automatic t_aie();
    wr(5'b00100);
    ilk();
    aie = 1'b1;
    wr(5'b00101);     ck("R4 integrity blocks", 5'b00100, 1, 1);
    aie = 1'b0;
    wr(5'b00101);     ck("R3 interlock kept", 5'b00101, 0, 1);
    idle(OPL);        ck("R2 program done", 5'b00101, 1, 1);
    wr(5'b00100);     ck("R5 terminate pgm", 5'b00100, 1, 1);
    wr(5'b00000);
  endtask

  task automatic t_combo();
    ilk();
    wr(5'b00001);     ck("R4 no mode", 5'b00000, 1, 1);
    wr(5'b00011);     ck("R12 mode before ehv", 5'b00011, 0, 1);
    wr(5'b00101);     ck("R11 mode locked", 5'b00011, 0, 1);
    idle(OPL - 2);    ck("R2 busy", 5'b00011, 0, 1);
    idle(1);          ck("R2 done", 5'b00011, 1, 1);
    wr(5'b00010);
    wr(5'b00000);     ck("R5 back idle", 5'b00000, 1, 1);
  endtask

  task automatic t_abort();
    ilk();
    wr(5'b00010);
    wr(5'b00011);     ck("R2 start", 5'b00011, 0, 1);
    wr(5'b00010);     ck("R6 abort", 5'b00010, 0, 0);
    wr(5'b00011);     ck("R6 ehv locked", 5'b00010, 0, 0);
    idle(1);          ck("R6 aborting", 5'b00010, 0, 0);
    idle(1);          ck("R6 abort end", 5'b00010, 1, 0);
    wr(5'b00011);     ck("R6 fresh interlock", 5'b00010, 1, 0);
    ilk();
    wr(5'b00011);     ck("R6 restart", 5'b00011, 0, 0);
    wr(5'b00010);
    idle(ABL);        ck("R6 second abort", 5'b00010, 1, 0);
    wr(5'b00000);
  endtask

  task automatic t_esus();
    ilk();
    wr(5'b00010);
    wr(5'b00011);
    wr(5'b01011);     ck("R7 suspend", 5'b01011, 0, 0);
    wr(5'b01010);     ck("R7 ehv locked", 5'b01011, 0, 0);
    idle(2);          ck("R7 suspending", 5'b01011, 0, 0);
    idle(1);          ck("R7 suspended", 5'b01011, 1, 0);
    wr(5'b01010);     ck("R8 no abort", 5'b01010, 1, 0);
    idle(5);          ck("R8 stays done", 5'b01010, 1, 0);
    wr(5'b01110);     ck("R9 pgm in suspend", 5'b01110, 1, 0);
    ilk();
    wr(5'b01111);     ck("R9 nested start", 5'b01111, 0, 0);
    idle(OPL - 1);    ck("R9 nested busy", 5'b01111, 0, 0);
    idle(1);          ck("R9 nested done", 5'b01111, 1, 1);
    wr(5'b01110);     ck("R9 nested end", 5'b01110, 1, 1);
    idle(3);          ck("R9 still suspended", 5'b01110, 1, 1);
    wr(5'b01010);     ck("R9 pgm clear", 5'b01010, 1, 1);
    wr(5'b00010);     ck("R10 resume needs ehv", 5'b01010, 1, 1);
    wr(5'b01011);     ck("R10 ehv in suspend", 5'b01011, 1, 1);
    wr(5'b00011);     ck("R10 resume", 5'b00011, 1, 1);
    wr(5'b00010);     ck("R10 ehv locked", 5'b00011, 1, 1);
    idle(2);          ck("R10 resuming", 5'b00011, 1, 1);
    idle(1);          ck("R10 running", 5'b00011, 0, 1);
    idle(OPL - 1);    ck("R10 busy", 5'b00011, 0, 1);
    idle(1);          ck("R10 complete", 5'b00011, 1, 1);
    wr(5'b00010);
    wr(5'b00000);
  endtask

  task automatic t_psus();
    ilk();
    wr(5'b00100);
    wr(5'b00101);
    wr(5'b10100);     ck("R12 suspend over ehv", 5'b10101, 0, 1);
    idle(3);          ck("R7 psus busy", 5'b10101, 0, 1);
    idle(1);          ck("R7 psus done", 5'b10101, 1, 1);
    wr(5'b00101);     ck("R10 psus resume", 5'b00101, 1, 1);
    idle(3);          ck("R10 psus resuming", 5'b00101, 1, 1);
    idle(1);          ck("R10 psus running", 5'b00101, 0, 1);
    idle(OPL);        ck("R2 psus complete", 5'b00101, 1, 1);
    wr(5'b00100);
    wr(5'b00000);     ck("R5 final idle", 5'b00000, 1, 1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_erase();
    t_aie();
    t_combo();
    t_abort();
    t_esus();
    t_psus();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end
endmodule